// File: doc/BRIEF.md
# TFT Panel Control Strobe Generator

This block drives the control strobes of a 240x320 TFT panel from one pixel-clock enable. It produces five pulse trains, each shaped as a pulse-width-modulated output with its own asserted width and period, counted in pixel-clock enables. The strobes are a per-line pulse, a sampling pulse, a frame-start pulse two lines wide, an active-low polarity/clear window, and a reversal signal that alternates from line to line. The line period is derived from the pixel-clock rate, the frame rate and the line count. A frame holds 329 lines: 320 visible lines and 9 blanking lines. With the default 6 MHz rate the line period is 303 clocks.

The strobes do not all start at once. A start request first releases the reversal counter. The line pulse is released only once the reversal count has passed 11. The sampling, frame-start and polarity strobes are then released together, once the line count has reached 3, and the configured flag rises at that point. A stop input halts all five strobes in one cycle and clears the flag. The next start request therefore runs the whole staggered sequence again.

Top module: `tft_strobe_gen`

## Requirements
- R1: After reset, line_pulse, sample_pulse, frame_pulse and rev_out are low, polclr_n is high and configured is low.
- R2: Once released, line_pulse is high for 1 count out of every LINE_CLKS counts. LINE_CLKS = PIX_HZ / FRAME_HZ / (VIS_LINES + BLANK_LINES), using integer division.
- R3: Once released, sample_pulse is high for 1 count out of every LINE_CLKS counts. Its phase starts at count 0 when the group is released.
- R4: Once released, frame_pulse is high for 2*LINE_CLKS counts out of every LINE_CLKS*(VIS_LINES+BLANK_LINES) counts.
- R5: Once released, polclr_n is low (active-low) for ACTIVE_PIX+POL_EXTRA counts out of every LINE_CLKS counts. It is high when it is not released.
- R6: Once released, rev_out is high for LINE_CLKS counts out of every 2*LINE_CLKS counts.
- R7: A start request while idle releases rev_out on the next clock with its count at 0. The line pulse is released on the clock after the reversal count first exceeds REV_GATE (11).
- R8: The sampling, frame-start and polarity strobes are released together on the clock after the line count first reaches at least LINE_GATE (3). configured rises on that same clock.
- R9: A start request has no effect while a start sequence is in progress or configured is high.
- R10: stop_req halts all five strobes on the next clock and clears configured. It takes priority over start_req. A later start repeats the full sequence from the beginning.
- R11: Every strobe counter starts at 0 when released and advances only on clocks where pix_en is high. Each counter wraps to 0 after reaching its period minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-clock enable; each high cycle is one count |
| start_req | input | 1 | Request to start the staggered release |
| stop_req | input | 1 | Halts all strobes and clears configured |
| line_pulse | output | 1 | Per-line pulse |
| sample_pulse | output | 1 | Per-line sampling pulse |
| frame_pulse | output | 1 | Frame-start pulse, two lines wide |
| polclr_n | output | 1 | Active-low polarity/clear window |
| rev_out | output | 1 | Reversal signal, toggles every line |
| configured | output | 1 | High once all strobes are running |

## Verification
The assertions assume that rst_n is released synchronously to the clock. They also assume that the line period is at least 2 counts and longer than the polarity window, so that a single-count pulse is always followed by a low count. The bench uses a reduced configuration that keeps these relations: a 20-count line, a 6-line frame and a 12-count polarity window. It drives every input on the falling edge only, so each input is stable across the rising edge at which the design samples it. Its stimulus covers steady enables, a gapped enable pattern, start requests during a run, and stop requests both during the release sequence and together with a start request.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
  // Strobe slot indices
  localparam int unsigned S_REV  = 0;
  localparam int unsigned S_LINE = 1;
  localparam int unsigned S_SAMP = 2;
  localparam int unsigned S_FRM  = 3;
  localparam int unsigned S_POL  = 4;
  localparam int unsigned N_STROBES = 5;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_WREV  = 2'd1,
    SQ_WLINE = 2'd2,
    SQ_LIVE  = 2'd3
  } seq_state_t;

  // Clocks per line from pixel rate, frame rate and lines per frame
  function automatic int unsigned line_clks(input int unsigned pix_hz,
                                            input int unsigned frame_hz,
                                            input int unsigned lines);
    return (pix_hz / frame_hz) / lines;
  endfunction

  // Asserted while count is below the width
  function automatic logic pwm_level(input int unsigned cnt,
                                     input int unsigned width);
    return cnt < width;
  endfunction

  // Next count with wrap at period-1
  function automatic int unsigned pwm_next(input int unsigned cnt,
                                           input int unsigned period);
    return (cnt >= period - 1) ? 0 : cnt + 1;
  endfunction
endpackage

// File: rtl/tsg_pwm_chan.sv
module tsg_pwm_chan
  import tsg_pkg::*;
#(
  parameter int unsigned CW      = 17,
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned PERIOD  = 303,
  parameter bit          ACT_LOW = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          pix_en,
  output logic [CW-1:0] cnt,
  output logic          level
);
  logic asserted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run) begin
      cnt <= '0;
    end else if (pix_en) begin
      cnt <= CW'(pwm_next(int'(cnt), PERIOD));
    end
  end

  assign asserted = run && pwm_level(int'(cnt), WIDTH);

  generate
    if (ACT_LOW) begin : g_low
      assign level = ~asserted;
    end else begin : g_high
      assign level = asserted;
    end
  endgenerate
endmodule

// File: rtl/tsg_sequencer.sv
module tsg_sequencer
  import tsg_pkg::*;
#(
  parameter int unsigned CW        = 17,
  parameter int unsigned REV_GATE  = 11,
  parameter int unsigned LINE_GATE = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_req,
  input  logic                 stop_req,
  input  logic [CW-1:0]        rev_cnt,
  input  logic [CW-1:0]        line_cnt,
  output logic [N_STROBES-1:0] run,
  output logic                 configured,
  output seq_state_t           state
);
  seq_state_t nxt;
  logic rev_gate_hit;
  logic line_gate_hit;

  assign rev_gate_hit  = rev_cnt > CW'(REV_GATE);
  assign line_gate_hit = line_cnt >= CW'(LINE_GATE);

  always_comb begin
    nxt = state;
    if (stop_req) begin
      nxt = SQ_IDLE;
    end else begin
      case (state)
        SQ_IDLE:  if (start_req)     nxt = SQ_WREV;
        SQ_WREV:  if (rev_gate_hit)  nxt = SQ_WLINE;
        SQ_WLINE: if (line_gate_hit) nxt = SQ_LIVE;
        default:  nxt = SQ_LIVE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SQ_IDLE;
      run        <= '0;
      configured <= 1'b0;
    end else begin
      state             <= nxt;
      run[S_REV]        <= (nxt != SQ_IDLE);
      run[S_LINE]       <= (nxt == SQ_WLINE) || (nxt == SQ_LIVE);
      run[S_SAMP]       <= (nxt == SQ_LIVE);
      run[S_FRM]        <= (nxt == SQ_LIVE);
      run[S_POL]        <= (nxt == SQ_LIVE);
      configured        <= (nxt == SQ_LIVE);
    end
  end
endmodule

// File: rtl/tft_strobe_gen.sv
module tft_strobe_gen
  import tsg_pkg::*;
#(
  parameter int unsigned PIX_HZ      = 6_000_000,
  parameter int unsigned FRAME_HZ    = 60,
  parameter int unsigned VIS_LINES   = 320,
  parameter int unsigned BLANK_LINES = 9,
  parameter int unsigned ACTIVE_PIX  = 240,
  parameter int unsigned POL_EXTRA   = 8,
  parameter int unsigned REV_GATE    = 11,
  parameter int unsigned LINE_GATE   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_en,
  input  logic start_req,
  input  logic stop_req,
  output logic line_pulse,
  output logic sample_pulse,
  output logic frame_pulse,
  output logic polclr_n,
  output logic rev_out,
  output logic configured
);
  localparam int unsigned FRAME_LINES = VIS_LINES + BLANK_LINES;
  localparam int unsigned LINE_CLKS   = line_clks(PIX_HZ, FRAME_HZ, FRAME_LINES);
  localparam int unsigned FRAME_CLKS  = LINE_CLKS * FRAME_LINES;
  localparam int unsigned CW          = $clog2(FRAME_CLKS + 1);

  // Per-slot shape: rev, line, sample, frame, polarity
  localparam int unsigned WID [N_STROBES] =
    '{LINE_CLKS, 1, 1, 2 * LINE_CLKS, ACTIVE_PIX + POL_EXTRA};
  localparam int unsigned PER [N_STROBES] =
    '{2 * LINE_CLKS, LINE_CLKS, LINE_CLKS, FRAME_CLKS, LINE_CLKS};

  // Named internal events for the checker
  logic [N_STROBES-1:0] run_vec;
  logic [N_STROBES-1:0] lvl_vec;
  logic [CW-1:0]        cnt_arr [N_STROBES];
  logic [CW-1:0]        rev_cnt;
  logic [CW-1:0]        line_cnt;
  seq_state_t           seq_state;

  tsg_sequencer #(
    .CW(CW), .REV_GATE(REV_GATE), .LINE_GATE(LINE_GATE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .rev_cnt(rev_cnt), .line_cnt(line_cnt), .run(run_vec),
    .configured(configured), .state(seq_state)
  );

  generate
    for (genvar g = 0; g < N_STROBES; g++) begin : g_chan
      tsg_pwm_chan #(
        .CW(CW), .WIDTH(WID[g]), .PERIOD(PER[g]), .ACT_LOW(g == S_POL)
      ) u_chan (
        .clk(clk), .rst_n(rst_n), .run(run_vec[g]), .pix_en(pix_en),
        .cnt(cnt_arr[g]), .level(lvl_vec[g])
      );
    end
  endgenerate

  assign rev_cnt      = cnt_arr[S_REV];
  assign line_cnt     = cnt_arr[S_LINE];
  assign rev_out      = lvl_vec[S_REV];
  assign line_pulse   = lvl_vec[S_LINE];
  assign sample_pulse = lvl_vec[S_SAMP];
  assign frame_pulse  = lvl_vec[S_FRM];
  assign polclr_n     = lvl_vec[S_POL];
endmodule

// File: rtl/tsg_checker.sv
module tsg_checker #(
  parameter int unsigned CW        = 17,
  parameter int unsigned REV_GATE  = 11,
  parameter int unsigned LINE_GATE = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_en,
  input logic          stop_req,
  input logic          line_pulse,
  input logic          sample_pulse,
  input logic          frame_pulse,
  input logic          polclr_n,
  input logic          rev_out,
  input logic          configured,
  input logic [4:0]    run_vec,
  input logic [CW-1:0] rev_cnt,
  input logic [CW-1:0] line_cnt
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!configured && !rev_out && polclr_n) || !rst_n);

  assert_line_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (line_pulse && pix_en && !stop_req) |=> !line_pulse);

  assert_sample_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_pulse && pix_en && !stop_req) |=> !sample_pulse);

  assert_line_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_vec[1]) |-> $past(rev_cnt) > CW'(REV_GATE));

  assert_group_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(configured) |-> ($past(line_cnt) >= CW'(LINE_GATE)) && (run_vec == 5'b11111));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (configured && !stop_req) |=> configured);

  assert_stop_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> (!configured && !line_pulse && !sample_pulse && !frame_pulse
                  && !rev_out && polclr_n));

  assert_hold_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (configured && !pix_en && !stop_req) |=> ($stable(line_cnt) && $stable(rev_cnt)));
endmodule

bind tft_strobe_gen tsg_checker #(
  .CW(CW), .REV_GATE(REV_GATE), .LINE_GATE(LINE_GATE)
) u_tsg_checker (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .stop_req(stop_req),
  .line_pulse(line_pulse), .sample_pulse(sample_pulse),
  .frame_pulse(frame_pulse), .polclr_n(polclr_n), .rev_out(rev_out),
  .configured(configured), .run_vec(run_vec), .rev_cnt(rev_cnt),
  .line_cnt(line_cnt)
);

// File: tb/test_tft_strobe_gen.sv
`timescale 1ns/1ps
module test_tft_strobe_gen;
  // Reduced configuration: 7200/60 = 120 clocks per frame, 6 lines -> 20 per line
  localparam int PIX_HZ = 7200, FRAME_HZ = 60, VIS = 4, BLK = 2;
  localparam int ACT = 10, EXTRA = 2, RGATE = 11, LGATE = 3;
  localparam int L = (PIX_HZ / FRAME_HZ) / (VIS + BLK);
  localparam int LF = L * (VIS + BLK);
  localparam int POLW = ACT + EXTRA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_en = 1'b0, start_req = 1'b0, stop_req = 1'b0;
  logic line_pulse, sample_pulse, frame_pulse, polclr_n, rev_out, configured;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tft_strobe_gen #(
    .PIX_HZ(PIX_HZ), .FRAME_HZ(FRAME_HZ), .VIS_LINES(VIS), .BLANK_LINES(BLK),
    .ACTIVE_PIX(ACT), .POL_EXTRA(EXTRA), .REV_GATE(RGATE), .LINE_GATE(LGATE)
  ) i_tft_strobe_gen (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .start_req(start_req),
    .stop_req(stop_req), .line_pulse(line_pulse), .sample_pulse(sample_pulse),
    .frame_pulse(frame_pulse), .polclr_n(polclr_n), .rev_out(rev_out),
    .configured(configured)
  );

  // Spec model: phase 0 idle, 1 rev only, 2 rev+line, 3 all strobes
  int ph = 0, rc = 0, lc = 0, gl = 0, gf = 0;
  always @(posedge clk) begin
    if (!rst_n || stop_req) begin
      ph <= 0; rc <= 0; lc <= 0; gl <= 0; gf <= 0;
    end else begin
      if (ph >= 1 && pix_en) rc <= (rc + 1) % (2 * L);
      if (ph >= 2 && pix_en) lc <= (lc + 1) % L;
      if (ph == 3 && pix_en) begin gl <= (gl + 1) % L; gf <= (gf + 1) % LF; end
      if (ph == 0 && start_req) begin ph <= 1; rc <= 0; end
      if (ph == 1 && rc > RGATE) begin ph <= 2; lc <= 0; end
      if (ph == 2 && lc >= LGATE) begin ph <= 3; gl <= 0; gf <= 0; end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic compare_all();
    chk("R2 line_pulse",   line_pulse,   ph >= 2 && lc == 0);
    chk("R3 sample_pulse", sample_pulse, ph == 3 && gl == 0);
    chk("R4 frame_pulse",  frame_pulse,  ph == 3 && gf < 2 * L);
    chk("R5 polclr_n",     polclr_n,     !(ph == 3 && gl < POLW));
    chk("R6 rev_out",      rev_out,      ph >= 1 && rc < L);
    chk("R8 configured",   configured,   ph == 3);
  endtask

  // One cycle: compare at the falling edge, then drive the next inputs
  task automatic step(input logic en, input logic st, input logic sp);
    @(negedge clk);
    cycles++;
    compare_all();
    pix_en = en; start_req = st; stop_req = sp;
  endtask

  always @(posedge clk) begin
    if (!done && cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 line_pulse", line_pulse, 1'b0);
    chk("R1 sample_pulse", sample_pulse, 1'b0);
    chk("R1 frame_pulse", frame_pulse, 1'b0);
    chk("R1 polclr_n", polclr_n, 1'b1);
    chk("R1 rev_out", rev_out, 1'b0);
    chk("R1 configured", configured, 1'b0);
    rst_n = 1'b1;
    step(1, 0, 0);

    // R7/R8: steady enables, configured must rise 17 cycles after the start edge
    step(1, 1, 0);
    for (int k = 0; k < 17; k++) begin
      step(1, 0, 0);
      if (k == 13) chk("R7 line released after rev count passes 11", line_pulse, 1'b1);
      if (k == 15) chk("R8 configured not yet high", configured, 1'b0);
    end
    step(1, 0, 0);
    chk("R8 configured rises with group", configured, 1'b1);
    for (int k = 0; k < 3 * LF; k++) step(1, 0, 0);

    // R9: start requests while running are ignored
    for (int k = 0; k < 2 * LF; k++) step(1, (k % 7) == 0, 0);

    // R11: gapped enable pattern
    for (int k = 0; k < 3 * LF; k++) step((k % 3) != 0, 0, 0);

    // R10: stop together with start; outputs idle afterwards
    step(1, 1, 1);
    step(1, 0, 0);
    chk("R10 configured cleared", configured, 1'b0);
    chk("R10 polclr_n idle high", polclr_n, 1'b1);
    chk("R10 rev_out halted", rev_out, 1'b0);
    for (int k = 0; k < 10; k++) step(1, 0, 0);

    // R10: restart with gapped enables, stop mid-sequence, restart again
    step(1, 1, 0);
    for (int k = 0; k < 8; k++) step((k % 2) == 0, 0, 0);
    step(1, 0, 1);
    for (int k = 0; k < 5; k++) step(1, 0, 0);
    step(1, 1, 0);
    for (int k = 0; k < 2 * LF; k++) step((k % 4) != 1, 0, 0);
    for (int k = 0; k < LF; k++) step(1, 0, 0);
    step(0, 0, 1);
    for (int k = 0; k < 5; k++) step(0, 0, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule